// File: doc/BRIEF.md
# Housekeeping SPI Responder

This block lets an external host reach an internal byte-wide register file over a four-wire serial link with an active-low chip select. The link runs in SPI mode 0. Each selection starts with a command byte, which picks the transfer kind. The second byte is a start address. Every byte after that is a data byte, and the address moves up by one after each data byte. Write data leaves the block as one-cycle strobes on a register port. Read data is fetched through the same port and shifted back out on the serial output.

The serial pins are sampled by the block's own clock `clk`. Synchronizing them to that clock is left to the surrounding logic. The register port has no back-pressure, because a serial host cannot be made to wait. A write strobe must be taken in the cycle it appears. Read data must follow the read address within one clock.

Top module: `hk_spi_responder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `spi_miso`, `reg_wr_valid` and `reg_rd_valid` are all 0.
- R2: `spi_mosi` is taken on each rising edge of `spi_sck`, most significant bit first. The strobe that a completed byte causes is visible in the clock cycle that follows the `clk` edge on which the eighth rising edge was detected.
- R3: `spi_miso` changes only one clock after a detected falling edge of `spi_sck`, or after chip select goes high. A read byte is sent most significant bit first. Its first bit appears on the falling edge that follows completion of the previous byte.
- R4: Command 0x80 writes a stream, 0x40 reads a stream, and 0xC0 reads and writes a stream. A stream lasts until `spi_csn` goes high.
- R5: A command with bits 7:6 = 11, bits 2:0 = 000 and bits 5:3 = n, where n is 1 to 7, reads and writes exactly n data bytes. Later bytes in the same selection cause no strobe, and `spi_miso` stays 0 for them.
- R6: Any other command byte is a no-op. Until `spi_csn` goes high there is no strobe of any kind, and `spi_miso` stays 0.
- R7: The second byte of a selection is the start address. Write strobes carry addresses that rise by one per data byte and wrap from 0xFF to 0x00.
- R8: In a read mode, `reg_rd_valid` pulses with `reg_rd_addr` set to the start address when the address byte completes. After each data byte that is not the last, it pulses again with the next address.
- R9: When `spi_csn` goes high, the bit count, a partly received byte and the command state are all cleared. `spi_miso` returns to 0.
- R10: `spi_miso` is 0 while no read data is being sent. This covers the command and address bytes and every byte of a write-only stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock. It samples the serial pins. |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_csn | input | 1 | Chip select from the host, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_wr_valid | output | 1 | One-cycle write strobe |
| reg_wr_addr | output | 8 | Write address |
| reg_wr_data | output | 8 | Write data |
| reg_rd_valid | output | 1 | One-cycle read fetch strobe |
| reg_rd_addr | output | 8 | Read address. It holds until the next fetch. |
| reg_rd_data | input | 8 | Read data. It must follow `reg_rd_addr` within one clock. |

## Verification
The properties assume that the serial pins are already synchronous to `clk`. They also assume that each high and each low phase of `spi_sck` lasts at least two clocks, and that `spi_sck` is low whenever `spi_csn` changes. The edge-timing checks on the strobes and on `spi_miso` depend on these assumptions. The stimulus keeps to them: it moves every input a quarter period after a rising clock edge, it holds each `spi_sck` phase for three clocks, and it toggles chip select only while the serial clock is low. The register-file stand-in in the bench derives its read data combinationally from the read address, so the one-clock read latency is always met.

// File: rtl/hk_spi_pkg.sv
package hk_spi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_DONE,
    ST_IGNORE
  } hk_state_e;

  typedef struct packed {
    logic       valid;
    logic       wr;
    logic       rd;
    logic       nbyte;
    logic [2:0] count;
  } hk_cmd_t;

  function automatic hk_cmd_t hk_decode(input logic [BYTE_W-1:0] c);
    hk_cmd_t d;
    d = '0;
    case (c)
      8'h80: begin d.valid = 1'b1; d.wr = 1'b1; end
      8'h40: begin d.valid = 1'b1; d.rd = 1'b1; end
      8'hC0: begin d.valid = 1'b1; d.wr = 1'b1; d.rd = 1'b1; end
      default: begin
        if (c[7:6] == 2'b11 && c[2:0] == 3'b000 && c[5:3] != 3'b000) begin
          d.valid = 1'b1;
          d.wr    = 1'b1;
          d.rd    = 1'b1;
          d.nbyte = 1'b1;
          d.count = c[5:3];
        end
      end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/hk_spi_rx.sv
module hk_spi_rx #(
  parameter int BYTE_W = hk_spi_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              sck,
  input  logic              mosi,
  output logic              fall_o,
  output logic              bit_zero_o,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic             sck_q;
  logic [CNT_W-1:0] bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic             rise;

  assign rise        = ~csn & sck & ~sck_q;
  assign fall_o      = ~csn & ~sck & sck_q;
  assign bit_zero_o  = (bitcnt == '0);
  assign byte_done_o = rise & (bitcnt == LAST_BIT);
  assign byte_o      = {shreg[BYTE_W-2:0], mosi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      bitcnt <= '0;
      shreg  <= '0;
    end else begin
      sck_q <= sck;
      if (csn) begin
        bitcnt <= '0;
      end else if (rise) begin
        shreg  <= {shreg[BYTE_W-2:0], mosi};
        bitcnt <= (bitcnt == LAST_BIT) ? '0 : bitcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hk_spi_ctrl.sv
module hk_spi_ctrl
  import hk_spi_pkg::*;
#(
  parameter int BYTE_W = hk_spi_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              send_o,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_addr
);
  hk_state_e         state;
  hk_cmd_t           cmd;
  hk_cmd_t           dec;
  logic [BYTE_W-1:0] addr;
  logic [2:0]        cnt;
  logic [2:0]        cnt_nxt;

  assign dec     = hk_decode(byte_in);
  assign cnt_nxt = cnt + 3'd1;
  assign send_o  = (state == ST_DATA) & cmd.rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_CMD;
      cmd      <= '0;
      addr     <= '0;
      cnt      <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_valid <= 1'b0;
      rd_addr  <= '0;
    end else begin
      wr_valid <= 1'b0;
      rd_valid <= 1'b0;
      if (csn) begin
        state <= ST_CMD;
        cmd   <= '0;
      end else if (byte_done) begin
        case (state)
          ST_CMD: begin
            cmd   <= dec;
            state <= dec.valid ? ST_ADDR : ST_IGNORE;
          end
          ST_ADDR: begin
            addr  <= byte_in;
            cnt   <= '0;
            state <= ST_DATA;
            if (cmd.rd) begin
              rd_valid <= 1'b1;
              rd_addr  <= byte_in;
            end
          end
          ST_DATA: begin
            if (cmd.wr) begin
              wr_valid <= 1'b1;
              wr_addr  <= addr;
              wr_data  <= byte_in;
            end
            addr <= addr + 1'b1;
            cnt  <= cnt_nxt;
            if (cmd.nbyte && cnt_nxt == cmd.count) begin
              state <= ST_DONE;
            end else if (cmd.rd) begin
              rd_valid <= 1'b1;
              rd_addr  <= addr + 1'b1;
            end
          end
          default: state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/hk_spi_tx.sv
module hk_spi_tx #(
  parameter int BYTE_W = hk_spi_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              fall,
  input  logic              bit_zero,
  input  logic              send,
  input  logic [BYTE_W-1:0] load_data,
  output logic              miso
);
  logic [BYTE_W-1:0] txsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miso <= 1'b0;
      txsh <= '0;
    end else if (csn) begin
      miso <= 1'b0;
    end else if (fall) begin
      if (send && bit_zero) begin
        miso <= load_data[BYTE_W-1];
        txsh <= {load_data[BYTE_W-2:0], 1'b0};
      end else if (send) begin
        miso <= txsh[BYTE_W-1];
        txsh <= {txsh[BYTE_W-2:0], 1'b0};
      end else begin
        miso <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hk_spi_responder.sv
module hk_spi_responder #(
  parameter int BYTE_W = hk_spi_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              reg_wr_valid,
  output logic [BYTE_W-1:0] reg_wr_addr,
  output logic [BYTE_W-1:0] reg_wr_data,
  output logic              reg_rd_valid,
  output logic [BYTE_W-1:0] reg_rd_addr,
  input  logic [BYTE_W-1:0] reg_rd_data
);
  logic              fall;
  logic              bit_zero;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              send;

  hk_spi_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .csn        (spi_csn),
    .sck        (spi_sck),
    .mosi       (spi_mosi),
    .fall_o     (fall),
    .bit_zero_o (bit_zero),
    .byte_done_o(byte_done),
    .byte_o     (rx_byte)
  );

  hk_spi_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn      (spi_csn),
    .byte_done(byte_done),
    .byte_in  (rx_byte),
    .send_o   (send),
    .wr_valid (reg_wr_valid),
    .wr_addr  (reg_wr_addr),
    .wr_data  (reg_wr_data),
    .rd_valid (reg_rd_valid),
    .rd_addr  (reg_rd_addr)
  );

  hk_spi_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn      (spi_csn),
    .fall     (fall),
    .bit_zero (bit_zero),
    .send     (send),
    .load_data(reg_rd_data),
    .miso     (spi_miso)
  );
endmodule

// File: rtl/hk_spi_responder_chk.sv
module hk_spi_responder_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_csn,
  input logic              spi_sck,
  input logic              spi_miso,
  input logic              reg_wr_valid,
  input logic [BYTE_W-1:0] reg_wr_addr,
  input logic              reg_rd_valid
);
  logic              seen_wr;
  logic [BYTE_W-1:0] last_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_wr <= 1'b0;
      last_wr <= '0;
    end else if (spi_csn) begin
      seen_wr <= 1'b0;
    end else if (reg_wr_valid) begin
      seen_wr <= 1'b1;
      last_wr <= reg_wr_addr;
    end
  end

  a_r9_csn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |=> (!reg_wr_valid && !reg_rd_valid && !spi_miso));

  a_r2_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_valid || reg_rd_valid) |-> ($past(spi_sck) && !$past(spi_sck, 2)));

  a_r3_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_miso) |-> ($past(spi_csn) || (!$past(spi_sck) && $past(spi_sck, 2))));

  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_valid && seen_wr) |-> (reg_wr_addr == last_wr + 1'b1));
endmodule

bind hk_spi_responder hk_spi_responder_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_csn     (spi_csn),
  .spi_sck     (spi_sck),
  .spi_miso    (spi_miso),
  .reg_wr_valid(reg_wr_valid),
  .reg_wr_addr (reg_wr_addr),
  .reg_rd_valid(reg_rd_valid)
);

// File: tb/sim_hk_spi_responder.sv
module sim_hk_spi_responder;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_csn = 1'b1;
  logic spi_sck = 1'b0;
  logic spi_mosi = 1'b0;
  logic spi_miso;
  logic reg_wr_valid;
  logic [7:0] reg_wr_addr;
  logic [7:0] reg_wr_data;
  logic reg_rd_valid;
  logic [7:0] reg_rd_addr;
  logic [7:0] reg_rd_data;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  logic [7:0] wa_q[$];
  logic [7:0] wd_q[$];

  assign reg_rd_data = reg_rd_addr ^ 8'hA5;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hk_spi_responder u0 (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_wr_valid(reg_wr_valid),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_valid(reg_rd_valid), .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising clock edge
  int m_bit, m_st, m_cnt, m_n;
  bit m_wr, m_rd, m_sck, m_miso;
  logic [7:0] m_sh, m_tx, m_addr;
  bit e_wr_v, e_rd_v;
  logic [7:0] e_wr_a, e_wr_d, e_rd_a;

  task automatic model_byte(input logic [7:0] b);
    if (m_st == 0) begin
      m_wr = 0; m_rd = 0; m_n = 0; m_st = 1;
      if (b == 8'h80) m_wr = 1;
      else if (b == 8'h40) m_rd = 1;
      else if (b == 8'hC0) begin m_wr = 1; m_rd = 1; end
      else if (b[7:6] == 2'b11 && b[2:0] == 0 && b[5:3] != 0) begin
        m_wr = 1; m_rd = 1; m_n = int'(b[5:3]);
      end else m_st = 3;
    end else if (m_st == 1) begin
      m_addr = b; m_cnt = 0; m_st = 2;
      if (m_rd) begin e_rd_v = 1; e_rd_a = b; end
    end else if (m_st == 2) begin
      if (m_wr) begin e_wr_v = 1; e_wr_a = m_addr; e_wr_d = b; end
      m_addr = m_addr + 8'd1;
      m_cnt++;
      if (m_n != 0 && m_cnt == m_n) m_st = 3;
      else if (m_rd) begin e_rd_v = 1; e_rd_a = m_addr; end
    end
  endtask

  always @(posedge clk) begin
    e_wr_v = 0; e_rd_v = 0;
    if (!rst_n) begin
      m_bit = 0; m_st = 0; m_sck = 0; m_miso = 0; m_sh = 0; m_tx = 0;
      e_wr_a = 0; e_wr_d = 0; e_rd_a = 0;
    end else begin
      if (spi_csn) begin
        m_bit = 0; m_st = 0; m_miso = 0;
      end else if (spi_sck && !m_sck) begin
        m_sh = {m_sh[6:0], spi_mosi};
        m_bit++;
        if (m_bit == 8) begin m_bit = 0; model_byte(m_sh); end
      end else if (!spi_sck && m_sck) begin
        if (m_st == 2 && m_rd) begin
          if (m_bit == 0) m_tx = e_rd_a ^ 8'hA5;
          m_miso = m_tx[7];
          m_tx = {m_tx[6:0], 1'b0};
        end else m_miso = 0;
      end
      m_sck = spi_sck;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_req, "wr_valid", int'(reg_wr_valid), int'(e_wr_v));
      check(cur_req, "rd_valid", int'(reg_rd_valid), int'(e_rd_v));
      check(cur_req, "miso", int'(spi_miso), int'(m_miso));
      if (e_wr_v) begin
        check(cur_req, "wr_addr", int'(reg_wr_addr), int'(e_wr_a));
        check(cur_req, "wr_data", int'(reg_wr_data), int'(e_wr_d));
      end
      if (e_rd_v) check(cur_req, "rd_addr", int'(reg_rd_addr), int'(e_rd_a));
      if (reg_wr_valid) begin wa_q.push_back(reg_wr_addr); wd_q.push_back(reg_wr_data); end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD / 4);
  endtask

  task automatic frame();
    rx_q.delete(); wa_q.delete(); wd_q.delete();
    spi_csn = 1'b0;
    step(HALF);
    foreach (tx_q[k]) begin
      logic [7:0] r;
      r = 8'h00;
      for (int i = 7; i >= 0; i--) begin
        spi_sck = 1'b0;
        spi_mosi = tx_q[k][i];
        step(HALF);
        r[i] = spi_miso;
        spi_sck = 1'b1;
        step(HALF);
      end
      rx_q.push_back(r);
    end
    spi_sck = 1'b0;
    step(HALF);
    spi_csn = 1'b1;
    step(4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(1);
    check("R1", "reset miso", int'(spi_miso), 0);
    check("R1", "reset wr_valid", int'(reg_wr_valid), 0);
    check("R1", "reset rd_valid", int'(reg_rd_valid), 0);
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R1", "post-reset miso", int'(spi_miso), 0);
    check("R1", "post-reset wr_valid", int'(reg_wr_valid), 0);
    step(4);

    // R2 R4 R10: write stream
    cur_req = "R4";
    tx_q = '{8'h80, 8'h10, 8'h11, 8'h22, 8'h33};
    frame();
    check("R4", "write stream count", wa_q.size(), 3);
    if (wa_q.size() == 3) begin
      check("R2", "wr data 0", int'(wd_q[0]), 8'h11);
      check("R7", "wr addr 2", int'(wa_q[2]), 8'h12);
    end
    for (int k = 0; k < 5; k++) check("R10", "write-only miso byte", int'(rx_q[k]), 0);

    // R3 R8: read stream
    cur_req = "R8";
    tx_q = '{8'h40, 8'h20, 8'h00, 8'h00, 8'h00};
    frame();
    check("R8", "read stream writes", wa_q.size(), 0);
    for (int k = 0; k < 3; k++)
      check("R3", "read byte", int'(rx_q[k + 2]), int'((8'h20 + k) ^ 8'hA5));
    check("R10", "miso during addr byte", int'(rx_q[1]), 0);

    // R7: read/write stream with address wrap
    cur_req = "R7";
    tx_q = '{8'hC0, 8'hFE, 8'hA1, 8'hB2, 8'hC3};
    frame();
    check("R7", "rw stream count", wa_q.size(), 3);
    if (wa_q.size() == 3) check("R7", "wrapped addr", int'(wa_q[2]), 8'h00);
    check("R3", "rw read byte at FF", int'(rx_q[3]), int'(8'hFF ^ 8'hA5));

    // R5: n-byte with n = 2, extra bytes ignored
    cur_req = "R5";
    tx_q = '{8'hD0, 8'h30, 8'h01, 8'h02, 8'h03, 8'h04};
    frame();
    check("R5", "n=2 write count", wa_q.size(), 2);
    check("R5", "miso after n bytes", int'(rx_q[4]), 0);
    check("R5", "miso second n byte", int'(rx_q[3]), int'(8'h31 ^ 8'hA5));

    // R5: n-byte with n = 7
    tx_q = '{8'hF8, 8'h50, 8'h0, 8'h1, 8'h2, 8'h3, 8'h4, 8'h5, 8'h6, 8'h7};
    frame();
    check("R5", "n=7 write count", wa_q.size(), 7);

    // R6: undefined commands
    cur_req = "R6";
    tx_q = '{8'h00, 8'h60, 8'h77, 8'h88};
    frame();
    check("R6", "cmd 00 writes", wa_q.size(), 0);
    tx_q = '{8'hC1, 8'h60, 8'h77, 8'h88};
    frame();
    check("R6", "cmd C1 writes", wa_q.size(), 0);
    check("R6", "cmd C1 miso", int'(rx_q[2]), 0);
    tx_q = '{8'h81, 8'h60, 8'h77};
    frame();
    check("R6", "cmd 81 writes", wa_q.size(), 0);

    // R9: partial byte then fresh frame
    cur_req = "R9";
    spi_csn = 1'b0;
    step(HALF);
    for (int i = 0; i < 5; i++) begin
      spi_sck = 1'b0; spi_mosi = 1'b1; step(HALF);
      spi_sck = 1'b1; step(HALF);
    end
    spi_sck = 1'b0; step(HALF);
    spi_csn = 1'b1; step(4);
    tx_q = '{8'h80, 8'h40, 8'h5A};
    frame();
    check("R9", "write after abort count", wa_q.size(), 1);
    if (wa_q.size() == 1) begin
      check("R9", "write after abort addr", int'(wa_q[0]), 8'h40);
      check("R9", "write after abort data", int'(wd_q[0]), 8'h5A);
    end

    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule